// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block lays a 32 by 32 two-colour pointer over a stream of palette-indexed pixels. Each incoming pixel carries its 8-bit palette index and its screen coordinates. The block decides whether that position falls under a visible cursor pixel. It then emits a 9-bit index one clock later. That index is either the original pixel index or one of two overlay entries placed just above the normal 256-entry palette.

The cursor shape is held in two planes of 32 words each, one word per cursor row. A mask word picks which pixels of the row are opaque. An image word picks, for the opaque pixels, which of the two overlay colours is shown. A position register sets the top-left corner. A small register port loads these words and gives read access to one general-purpose control word. Coverage stops at the active screen width, so a cursor near the right edge is cut off. After reset the cursor sits far to the right, past any real screen.

Top module: `cursor_overlay_mix`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, the control word reads as 0x02000000, the cursor column is 0xF000, the cursor row is 0 and all shape words are 0. As a result, no pixel of a screen narrower than 0xF000 is overlaid until the position is written.
- R2: A read at offset 0x818 returns the last value written to that offset with bit 25 forced to 1. A read at any other offset returns 0.
- R3: A write to offset 0x8FC sets the cursor column from data bits 31:16 and the cursor row from data bits 15:0.
- R4: A write to offset 0x900 + 4*r (r from 0 to 31) loads the mask word of cursor row r. A write to offset 0x980 + 4*r loads the image word of cursor row r.
- R5: Where the selected mask bit is 0, the output index equals the input index zero-extended to 9 bits.
- R6: Where the selected mask bit is 1, the output index is 259 if the matching image bit is 1 and 258 if it is 0.
- R7: The pixel at horizontal distance c (0 to 31) from the cursor column uses bit 31-c of the row's words, so bit 31 is the leftmost pixel.
- R8: Only lines y with cursor_row <= y < cursor_row + 32 can be overlaid. Line y uses cursor row y - cursor_row.
- R9: Only pixels x with cursor_col <= x < cursor_col + 32 and x < screen width can be overlaid. The cursor is therefore clipped at the right edge, and a cursor column at or beyond the width shows nothing.
- R10: `out_valid` equals `in_valid` of the previous clock. A valid output carries the coordinates and the mixed index of the pixel presented one clock earlier, computed with the register contents in place at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| scr_width | input | 16 | Active screen width in pixels |
| in_valid | input | 1 | Input pixel valid |
| in_x | input | 16 | Input pixel column |
| in_y | input | 16 | Input pixel line |
| in_idx | input | 8 | Input pixel palette index |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel line |
| out_idx | output | 9 | Mixed palette index (0 to 259) |

## Verification
A corrupted shape word, a wrong row or column select, or a swapped colour choice shows on `out_idx` one clock after the affected pixel enters. It shows only when that pixel lies inside the cursor square, so the bench scans whole windows around the cursor edges rather than single points. A bad position or clip comparison appears as a shifted or leaking overlay at the first pixel past the boundary. A wrong control word appears on `reg_rdata` at once.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 'h818;
  localparam int OFS_POS  = 'h8FC;
  localparam int OFS_MASK = 'h900;
  localparam int OFS_IMG  = 'h980;
  // control word bit always read back as one
  localparam int CTRL_FLAG_BIT = 25;
  // column value after reset: beyond any screen
  localparam int CURSX_RESET = 'hF000;
  // overlay entries counted above the base palette
  localparam int OVL_BG_STEP = 2;
  localparam int OVL_FG_STEP = 3;
endpackage

// File: rtl/cursor_ovl_regs.sv
module cursor_ovl_regs
  import cursor_ovl_pkg::*;
#(
  parameter int CUR_H   = 32,
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [COORD_W-1:0]             cur_x,
  output logic [COORD_W-1:0]             cur_y,
  output logic [CUR_H-1:0][DATA_W-1:0]   mask_rows,
  output logic [CUR_H-1:0][DATA_W-1:0]   img_rows
);
  localparam logic [ADDR_W-1:0]  A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0]  A_POS  = ADDR_W'(OFS_POS);
  localparam logic [DATA_W-1:0]  FLAG   = DATA_W'(1) << CTRL_FLAG_BIT;
  localparam logic [COORD_W-1:0] X_RST  = COORD_W'(CURSX_RESET);

  logic                pos_we, ctrl_we;
  logic [COORD_W-1:0]  cur_x_d, cur_y_d;
  logic [COORD_W-1:0]  cur_x_q, cur_y_q;
  logic [DATA_W-1:0]   ctrl_q;

  // decode and next state
  always_comb begin
    pos_we  = wr_en && (addr == A_POS);
    ctrl_we = wr_en && (addr == A_CTRL);
    cur_x_d = wdata[DATA_W-1 -: COORD_W];
    cur_y_d = wdata[COORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_x_q <= X_RST;
      cur_y_q <= '0;
    end else if (pos_we) begin
      cur_x_q <= cur_x_d;
      cur_y_q <= cur_y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata;
  end

  // one mask word and one image word per cursor row
  for (genvar r = 0; r < CUR_H; r++) begin : g_row
    localparam logic [ADDR_W-1:0] A_M = ADDR_W'(OFS_MASK + 4 * r);
    localparam logic [ADDR_W-1:0] A_I = ADDR_W'(OFS_IMG + 4 * r);
    logic m_en, i_en;
    logic [DATA_W-1:0] m_q, i_q;

    always_comb begin
      m_en = wr_en && (addr == A_M);
      i_en = wr_en && (addr == A_I);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    m_q <= '0;
      else if (m_en) m_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    i_q <= '0;
      else if (i_en) i_q <= wdata;
    end

    assign mask_rows[r] = m_q;
    assign img_rows[r]  = i_q;
  end

  always_comb begin
    rdata = (addr == A_CTRL) ? (ctrl_q | FLAG) : '0;
  end

  assign cur_x = cur_x_q;
  assign cur_y = cur_y_q;
endmodule

// File: rtl/cursor_ovl_hit.sv
module cursor_ovl_hit #(
  parameter int CUR_H   = 32,
  parameter int CUR_W   = 32,
  parameter int COORD_W = 16
) (
  input  logic [COORD_W-1:0]           cur_x,
  input  logic [COORD_W-1:0]           cur_y,
  input  logic [COORD_W-1:0]           scr_width,
  input  logic [COORD_W-1:0]           in_x,
  input  logic [COORD_W-1:0]           in_y,
  input  logic [CUR_H-1:0][CUR_W-1:0]  mask_rows,
  input  logic [CUR_H-1:0][CUR_W-1:0]  img_rows,
  output logic                         hit,
  output logic                         fg
);
  localparam int ROW_AW = $clog2(CUR_H);
  localparam int COL_AW = $clog2(CUR_W);
  localparam logic [COORD_W:0] Y_LIM = (COORD_W+1)'(CUR_H);
  localparam logic [COORD_W:0] X_LIM = (COORD_W+1)'(CUR_W);

  logic [COORD_W:0]  dy, dx;
  logic              y_in, x_in;
  logic [ROW_AW-1:0] row;
  logic [COL_AW-1:0] bsel;

  always_comb begin
    dy   = {1'b0, in_y} - {1'b0, cur_y};
    dx   = {1'b0, in_x} - {1'b0, cur_x};
    y_in = (in_y >= cur_y) && (dy < Y_LIM);
    x_in = (in_x >= cur_x) && (dx < X_LIM) && (in_x < scr_width);
    row  = dy[ROW_AW-1:0];
    // leftmost pixel takes the top bit of the word
    bsel = ~dx[COL_AW-1:0];
    hit  = y_in && x_in && mask_rows[row][bsel];
    fg   = img_rows[row][bsel];
  end
endmodule

// File: rtl/cursor_ovl_mix.sv
module cursor_ovl_mix
  import cursor_ovl_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [COORD_W-1:0]  in_x,
  input  logic [COORD_W-1:0]  in_y,
  input  logic [PIX_W-1:0]    in_idx,
  input  logic                hit,
  input  logic                fg,
  output logic                out_valid,
  output logic [COORD_W-1:0]  out_x,
  output logic [COORD_W-1:0]  out_y,
  output logic [PIX_W:0]      out_idx
);
  localparam int OUT_W = PIX_W + 1;
  localparam logic [OUT_W-1:0] IDX_BG = OUT_W'((1 << PIX_W) + OVL_BG_STEP);
  localparam logic [OUT_W-1:0] IDX_FG = OUT_W'((1 << PIX_W) + OVL_FG_STEP);

  logic              ce;
  logic [OUT_W-1:0]  idx_d;
  logic              vld_q;
  logic [COORD_W-1:0] x_q, y_q;
  logic [OUT_W-1:0]  idx_q;

  always_comb begin
    ce    = in_valid;
    idx_d = hit ? (fg ? IDX_FG : IDX_BG) : {1'b0, in_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      idx_q <= '0;
    end else if (ce) begin
      x_q   <= in_x;
      y_q   <= in_y;
      idx_q <= idx_d;
    end
  end

  assign out_valid = vld_q;
  assign out_x     = x_q;
  assign out_y     = y_q;
  assign out_idx   = idx_q;
endmodule

// File: rtl/cursor_overlay_mix.sv
module cursor_overlay_mix #(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8,
  parameter int CUR_H   = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [COORD_W-1:0]  scr_width,
  input  logic                in_valid,
  input  logic [COORD_W-1:0]  in_x,
  input  logic [COORD_W-1:0]  in_y,
  input  logic [PIX_W-1:0]    in_idx,
  output logic                out_valid,
  output logic [COORD_W-1:0]  out_x,
  output logic [COORD_W-1:0]  out_y,
  output logic [PIX_W:0]      out_idx
);
  // one cursor row is one register word
  localparam int CUR_W = DATA_W;

  logic [COORD_W-1:0]                cur_x, cur_y;
  logic [CUR_H-1:0][CUR_W-1:0]       mask_rows, img_rows;
  logic                              hit, fg;

  cursor_ovl_regs #(
    .CUR_H(CUR_H), .COORD_W(COORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cur_x(cur_x), .cur_y(cur_y),
    .mask_rows(mask_rows), .img_rows(img_rows)
  );

  cursor_ovl_hit #(
    .CUR_H(CUR_H), .CUR_W(CUR_W), .COORD_W(COORD_W)
  ) u_hit (
    .cur_x(cur_x), .cur_y(cur_y), .scr_width(scr_width),
    .in_x(in_x), .in_y(in_y), .mask_rows(mask_rows), .img_rows(img_rows),
    .hit(hit), .fg(fg)
  );

  cursor_ovl_mix #(
    .COORD_W(COORD_W), .PIX_W(PIX_W)
  ) u_mix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_idx(in_idx), .hit(hit), .fg(fg), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y), .out_idx(out_idx)
  );
endmodule

// File: rtl/cursor_overlay_mix_chk.sv
module cursor_overlay_mix_chk
  import cursor_ovl_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [COORD_W-1:0]  scr_width,
  input logic                in_valid,
  input logic [COORD_W-1:0]  in_x,
  input logic [COORD_W-1:0]  in_y,
  input logic [PIX_W-1:0]    in_idx,
  input logic                out_valid,
  input logic [COORD_W-1:0]  out_x,
  input logic [COORD_W-1:0]  out_y,
  input logic [PIX_W:0]      out_idx
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [PIX_W:0]    TOP    = (PIX_W+1)'((1 << PIX_W) + OVL_FG_STEP);

  p_rdata_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != A_CTRL) |-> (reg_rdata == '0));

  p_rdata_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> reg_rdata[CTRL_FLAG_BIT]);

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx <= TOP));

  p_valid_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_bubble_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_coord_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_x == $past(in_x)) && (out_y == $past(in_y)));

  p_edge_clip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_x >= scr_width)) |=> (out_idx == {1'b0, $past(in_idx)}));
endmodule

bind cursor_overlay_mix cursor_overlay_mix_chk #(
  .COORD_W(COORD_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .scr_width(scr_width), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .in_idx(in_idx), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
  .out_idx(out_idx)
);

// File: tb/sim_cursor_overlay_mix.sv
module sim_cursor_overlay_mix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] scr_width = 16'd640;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic [7:0]  in_idx = '0;
  logic        out_valid;
  logic [15:0] out_x, out_y;
  logic [8:0]  out_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cursor_overlay_mix u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scr_width(scr_width),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_idx(in_idx),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_idx(out_idx)
  );

  // ---------------- behavioural reference ----------------
  int          m_cx, m_cy;
  logic [31:0] m_mask [32];
  logic [31:0] m_img  [32];
  bit          e_valid = 1'b0;
  int          e_x, e_y, e_idx;
  string       e_tag;

  function automatic int ref_pix(input int x, input int y, input int idx,
                                 input int w, output string tag);
    int r, c;
    if (y < m_cy || y >= m_cy + 32) begin tag = "R8"; return idx; end
    if (x < m_cx || x >= m_cx + 32 || x >= w) begin tag = "R9"; return idx; end
    r = y - m_cy;
    c = x - m_cx;
    if (!m_mask[r][31-c]) begin tag = "R5"; return idx; end
    tag = "R6 R7";
    return m_img[r][31-c] ? 259 : 258;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 1'b0;
      m_cx = 'hF000;
      m_cy = 0;
      for (int i = 0; i < 32; i++) begin m_mask[i] = '0; m_img[i] = '0; end
    end else begin
      e_valid = in_valid;
      if (in_valid) begin
        e_x = in_x;
        e_y = in_y;
        e_idx = ref_pix(int'(in_x), int'(in_y), int'(in_idx), int'(scr_width), e_tag);
      end
      if (reg_wr_en) begin
        if (reg_addr == 12'h8FC) begin
          m_cx = int'(reg_wdata[31:16]);
          m_cy = int'(reg_wdata[15:0]);
        end
        for (int i = 0; i < 32; i++) begin
          if (reg_addr == 12'(12'h900 + 4 * i)) m_mask[i] = reg_wdata;
          if (reg_addr == 12'(12'h980 + 4 * i)) m_img[i] = reg_wdata;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == e_valid, "R10 valid", out_valid, e_valid);
      if (e_valid) begin
        check(int'(out_idx) == e_idx, e_tag, out_idx, e_idx);
        check(int'(out_x) == e_x && int'(out_y) == e_y, "R10 coords",
              {out_x, out_y}, {e_x[15:0], e_y[15:0]});
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = 12'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    reg_addr = 12'(a);
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic px(input int x, input int y, input int idx);
    in_valid = 1'b1; in_x = 16'(x); in_y = 16'(y); in_idx = 8'(idx);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic px_chk(input int x, input int y, input int idx, input int exp, input string tag);
    px(x, y, idx);
    check(int'(out_idx) == exp, tag, out_idx, exp);
  endtask

  function automatic logic [31:0] mask_pat(input int r);
    return 32'hC000_0003 | (32'(r) << 10);
  endfunction

  function automatic logic [31:0] img_pat(input int r);
    return 32'hAAAA_AAAA ^ 32'(r);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rd_chk('h818, 32'h0200_0000, "R1 control word in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    // R1: parked cursor overlays nothing, even at the origin
    px_chk(0, 0, 7, 7, "R1 parked cursor");
    px_chk(639, 0, 9, 9, "R1 parked cursor");

    // R2: control word and other offsets
    wr('h818, 32'h0000_0011);
    rd_chk('h818, 32'h0200_0011, "R2 control readback");
    rd_chk('h8FC, 32'h0, "R2 position reads zero");
    rd_chk('h900, 32'h0, "R2 mask reads zero");

    // R4: shape rows
    for (int r = 0; r < 32; r++) wr('h900 + 4 * r, mask_pat(r));
    for (int r = 0; r < 32; r++) wr('h980 + 4 * r, img_pat(r));

    // R3: position
    wr('h8FC, {16'd100, 16'd50});
    px_chk(100, 50, 1, 259, "R3 corner pixel");
    px_chk(99, 50, 2, 2, "R3 left of corner");
    px_chk(100, 49, 3, 3, "R3 above corner");
    px_chk(101, 50, 4, 258, "R6 background colour");
    px_chk(102, 50, 5, 5, "R5 transparent");
    px_chk(131, 50, 6, 258, "R7 rightmost column");
    px_chk(131, 51, 6, 259, "R4 image row 1");
    px_chk(119, 55, 8, 258, "R4 mask row 5");
    px_chk(100, 81, 9, 259, "R8 last row");
    px_chk(100, 82, 10, 10, "R8 past last row");

    // scan around the whole cursor square
    for (int y = 48; y <= 84; y++)
      for (int x = 96; x <= 136; x++) px(x, y, x & 255);

    // bubbles: R10
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 bubble", out_valid, 0);

    // right edge clipping: R9
    wr('h900, 32'hFFFF_FFFF);
    wr('h8FC, {16'd630, 16'd10});
    px_chk(639, 10, 11, 258, "R9 last visible column");
    px_chk(640, 10, 12, 12, "R9 clipped at width");
    for (int y = 9; y <= 12; y++)
      for (int x = 620; x <= 670; x++) px(x, y, (x + y) & 255);
    wr('h8FC, {16'd650, 16'd10});
    px_chk(650, 10, 13, 13, "R9 column beyond width");
    scr_width = 16'd700;
    @(negedge clk);
    px_chk(650, 10, 14, 259, "R9 wider screen");
    for (int x = 640; x <= 690; x++) px(x, 10, x & 255);

    // vertical position near the top of the coordinate range: R8
    wr('h8FC, {16'd0, 16'hFFF0});
    px_chk(5, 5, 15, 15, "R8 no wraparound");
    px_chk(0, 'hFFF5, 16, 259, "R8 high row");
    for (int y = 'hFFE0; y <= 'hFFFF; y++)
      for (int x = 0; x <= 33; x++) px(x, y, y & 255);

    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule